// File: doc/BRIEF.md
# Carry-Increment Group Adder

A combinational adder of parameterized width. It adds two operands and a carry-in, and it returns the sum and the carry-out. The word is cut into groups. Each group first resolves its internal carries under the assumption that no carry enters it. Running generate and propagate terms are accumulated from the group's lowest bit upward for this step. When the real carry into the group is known, an increment-style correction fixes every internal carry at once: the carry into a bit becomes the running generate below it, OR the running propagate below it ANDed with the group carry-in.

The bitwise generate/propagate stage runs once per bit, and so does the final sum XOR. Neither is repeated per assumed carry value. Each group's carry-out feeds the next group. Group sizes are uniform by default. A parameter makes them grow by one bit per group along the word, so that later groups can absorb the later arrival of their carry-in. The last group is clipped to the word width.

Top module: `cig_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of opA + opB + carryIn for every input combination.
- R2: `carryOut` equals bit WIDTH of opA + opB + carryIn, the carry leaving the most significant bit.
- R3: With GROWING = 0, every group is GROUP_BITS wide except a clipped final group, and R1 and R2 still hold.
- R4: With GROWING = 1, group k is GROUP_BITS + k bits wide except a clipped final group, and R1 and R2 still hold.
- R5: A carry-in of 1 with opA all ones and opB zero travels through every group. The result is sum = 0 and carryOut = 1.
- R6: When the most significant bits of both operands are 1, carryOut is 1. When both are 0, carryOut is 0.
- R7: sum[0] equals opA[0] XOR opB[0] XOR carryIn.
- R8: The outputs depend only on the present inputs. Applying the same inputs again gives the same outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum, modulo 2^WIDTH |
| carryOut | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach is a carry that is born in the lowest group and must pass through the increment correction of every later group, including the clipped final group. Random operands almost never propagate across a whole 32- or 64-bit word. Directed all-ones/zero and alternating patterns are therefore applied with both carry-in values, on top of the random vectors. At 8 bits, an exhaustive sweep over every operand pair and carry-in covers every group boundary, in both the uniform layout and the growing layout.

// File: rtl/cig_pkg.sv
package cig_pkg;

  function automatic int grpSize(input int idx, input int grp, input bit growing);
    return growing ? grp + idx : grp;
  endfunction

  function automatic int grpBase(input int idx, input int grp, input bit growing);
    int acc;
    acc = 0;
    for (int k = 0; k < idx; k++) acc += grpSize(k, grp, growing);
    return acc;
  endfunction

  function automatic int grpCount(input int width, input int grp, input bit growing);
    int n;
    int acc;
    n = 0;
    acc = 0;
    while (acc < width) begin
      acc += grpSize(n, grp, growing);
      n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/cig_pg.sv
module cig_pg #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] bitGen,
  output logic [WIDTH-1:0] bitProp
);
  // one generate/propagate pair per bit, shared by both carry cases
  assign bitGen  = opA & opB;
  assign bitProp = opA ^ opB;
endmodule

// File: rtl/cig_group.sv
module cig_group #(
  parameter int SIZE = 4
) (
  input  logic [SIZE-1:0] gen,
  input  logic [SIZE-1:0] prop,
  input  logic            groupCin,
  output logic [SIZE-1:0] bitCarry,
  output logic            groupCout
);
  logic [SIZE-1:0] runGen;
  logic [SIZE-1:0] runProp;

  // running terms from the group base: the carries for a zero carry-in
  assign runGen[0]  = gen[0];
  assign runProp[0] = prop[0];
  for (genvar m = 1; m < SIZE; m++) begin : g_run
    assign runGen[m]  = gen[m] | (prop[m] & runGen[m-1]);
    assign runProp[m] = prop[m] & runProp[m-1];
  end

  // increment correction once the real carry-in is known
  assign bitCarry[0] = groupCin;
  for (genvar m = 1; m < SIZE; m++) begin : g_fix
    assign bitCarry[m] = runGen[m-1] | (runProp[m-1] & groupCin);
  end
  assign groupCout = runGen[SIZE-1] | (runProp[SIZE-1] & groupCin);
endmodule

// File: rtl/cig_sum.sv
module cig_sum #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] bitProp,
  input  logic [WIDTH-1:0] carryVec,
  output logic [WIDTH-1:0] sum
);
  // single final XOR per bit
  assign sum = bitProp ^ carryVec;
endmodule

// File: rtl/cig_adder.sv
module cig_adder #(
  parameter int WIDTH      = 32,
  parameter int GROUP_BITS = 4,
  parameter bit GROWING    = 1'b0
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut
);
  import cig_pkg::*;

  localparam int NUM_GROUPS = grpCount(WIDTH, GROUP_BITS, GROWING);

  logic [WIDTH-1:0]    bitGen;
  logic [WIDTH-1:0]    bitProp;
  logic [WIDTH-1:0]    carryVec;
  logic [NUM_GROUPS:0] groupCarry;

  cig_pg #(.WIDTH(WIDTH)) u_pg (
    .opA(opA), .opB(opB), .bitGen(bitGen), .bitProp(bitProp)
  );

  assign groupCarry[0] = carryIn;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int BASE = grpBase(g, GROUP_BITS, GROWING);
    localparam int FULL = grpSize(g, GROUP_BITS, GROWING);
    localparam int SZ   = (BASE + FULL > WIDTH) ? (WIDTH - BASE) : FULL;
    cig_group #(.SIZE(SZ)) u_group (
      .gen      (bitGen[BASE +: SZ]),
      .prop     (bitProp[BASE +: SZ]),
      .groupCin (groupCarry[g]),
      .bitCarry (carryVec[BASE +: SZ]),
      .groupCout(groupCarry[g+1])
    );
  end

  cig_sum #(.WIDTH(WIDTH)) u_sum (
    .bitProp(bitProp), .carryVec(carryVec), .sum(sum)
  );

  assign carryOut = groupCarry[NUM_GROUPS];
endmodule

// File: rtl/cig_adder_chk.sv
module cig_adder_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             carryIn,
  input logic [WIDTH-1:0] sum,
  input logic             carryOut
);
  logic [WIDTH:0] total;
  assign total = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};

  always_comb begin
    if (!$isunknown({opA, opB, carryIn})) begin
      p_sum_match_r1: assert (sum == total[WIDTH-1:0])
        else $error("R1 sum mismatch");
      p_carry_out_r2: assert (carryOut == total[WIDTH])
        else $error("R2 carry-out mismatch");
      p_msb_gen_r6: assert (!(opA[WIDTH-1] && opB[WIDTH-1]) || carryOut)
        else $error("R6 carry-out missing");
      p_msb_kill_r6: assert (opA[WIDTH-1] || opB[WIDTH-1] || !carryOut)
        else $error("R6 carry-out spurious");
      p_lsb_r7: assert (sum[0] == (opA[0] ^ opB[0] ^ carryIn))
        else $error("R7 bit 0 wrong");
    end
  end
endmodule

bind cig_adder cig_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .opA(opA), .opB(opB), .carryIn(carryIn), .sum(sum), .carryOut(carryOut)
);

// File: tb/cig_adder_tb.sv
module cig_adder_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // 32-bit growing groups (2,3,4,5,6,7, clipped 5)
  logic [31:0] a32, b32, s32;
  logic        c32, co32;
  cig_adder #(.WIDTH(32), .GROUP_BITS(2), .GROWING(1'b1)) u_dut (
    .opA(a32), .opB(b32), .carryIn(c32), .sum(s32), .carryOut(co32));

  // 64-bit uniform groups of 4
  logic [63:0] a64, b64, s64;
  logic        c64, co64;
  cig_adder #(.WIDTH(64), .GROUP_BITS(4), .GROWING(1'b0)) u_dut64 (
    .opA(a64), .opB(b64), .carryIn(c64), .sum(s64), .carryOut(co64));

  // 8-bit: uniform groups of 3 (clipped last) and growing groups from 2
  logic [7:0] a8, b8, s8u, s8v;
  logic       c8, co8u, co8v;
  cig_adder #(.WIDTH(8), .GROUP_BITS(3), .GROWING(1'b0)) u_dut8u (
    .opA(a8), .opB(b8), .carryIn(c8), .sum(s8u), .carryOut(co8u));
  cig_adder #(.WIDTH(8), .GROUP_BITS(2), .GROWING(1'b1)) u_dut8v (
    .opA(a8), .opB(b8), .carryIn(c8), .sum(s8v), .carryOut(co8v));

  function automatic logic [64:0] ref64(logic [63:0] a, logic [63:0] b, logic c);
    return {1'b0, a} + {1'b0, b} + {64'd0, c};
  endfunction

  task automatic check(string req, logic [64:0] act, logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run32(logic [31:0] a, logic [31:0] b, logic c, string req);
    logic [64:0] e;
    @(posedge clk); a32 <= a; b32 <= b; c32 <= c;
    @(negedge clk);
    e = ref64({32'd0, a}, {32'd0, b}, c);
    check({req, " sum32"}, {33'd0, s32}, {33'd0, e[31:0]});
    check({req, " cout32"}, {64'd0, co32}, {64'd0, e[32]});
  endtask

  task automatic run64(logic [63:0] a, logic [63:0] b, logic c, string req);
    logic [64:0] e;
    @(posedge clk); a64 <= a; b64 <= b; c64 <= c;
    @(negedge clk);
    e = ref64(a, b, c);
    check({req, " sum64"}, {1'b0, s64}, {1'b0, e[63:0]});
    check({req, " cout64"}, {64'd0, co64}, {64'd0, e[64]});
  endtask

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 195000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected<195000", wd);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] seedDummy;
    seedDummy = $urandom(32'h1234_5678);
    a32 = '0; b32 = '0; c32 = 1'b0;
    a64 = '0; b64 = '0; c64 = 1'b0;
    a8 = '0; b8 = '0; c8 = 1'b0;
    @(negedge clk);
    // idle state with zero inputs (R1, R2)
    check("R1 idle sum", {33'd0, s32}, 65'd0);
    check("R2 idle cout", {64'd0, co64}, 65'd0);

    // R5: carry-in travels the whole word
    run32('1, '0, 1'b1, "R5");
    check("R5 sum32 zero", {33'd0, s32}, 65'd0);
    check("R5 cout32 one", {64'd0, co32}, 65'd1);
    run64('1, '0, 1'b1, "R5");
    check("R5 cout64 one", {64'd0, co64}, 65'd1);
    // R6: top-bit generate and kill corners
    run32('1, '1, 1'b0, "R6");
    run32('1, '1, 1'b1, "R6");
    run64(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, "R6");
    run64(64'h7fff_ffff_ffff_ffff, 64'h0, 1'b1, "R6");
    run32(32'h5555_5555, 32'haaaa_aaaa, 1'b1, "R5");
    run64(64'haaaa_aaaa_aaaa_aaaa, 64'h5555_5555_5555_5555, 1'b1, "R5");
    run64(64'h0f0f_0f0f_0f0f_0f0f, 64'hf0f0_f0f0_f0f0_f0f1, 1'b0, "R3");

    // R8: repeat identical inputs
    run32(32'hdead_beef, 32'h1234_5678, 1'b1, "R8 first");
    run32(32'hdead_beef, 32'h1234_5678, 1'b1, "R8 repeat");

    // random R4 (32-bit growing) and R3 (64-bit uniform)
    for (int i = 0; i < 2000; i++)
      run32($urandom, $urandom, 1'($urandom), "R4 R1 R2");
    for (int i = 0; i < 2000; i++)
      run64({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R3 R1 R2");

    // exhaustive 8-bit on both layouts (R3, R4, R7)
    for (int c = 0; c < 2; c++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          logic [8:0] e;
          @(posedge clk); a8 <= 8'(a); b8 <= 8'(b); c8 <= 1'(c);
          @(negedge clk);
          e = 9'(a) + 9'(b) + 9'(c);
          check("R3 exhaustive uniform", {56'd0, co8u, s8u}, {56'd0, e});
          check("R4 exhaustive growing", {56'd0, co8v, s8v}, {56'd0, e});
          check("R7 bit0", {64'd0, s8v[0]}, {64'd0, 1'(a ^ b ^ c)});
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule